// File: doc/BRIEF.md
# NAND bad block scanner

This block walks an inclusive range of erase blocks on a NAND device and records which of them carry a factory bad-block marker. On a start pulse it captures the range bounds, the device geometry (pages per erase block, page-size class, bus width) and the number of blocks on the device. It then issues one read request per block, for the spare area of that block's first page, and classifies the block from the six spare bytes that come back. The NAND bus cycles themselves belong to the agent that serves the read port.

Range bounds are clamped, not rejected. A start index that is negative or past the device is pulled back to block zero. An end index of -1, or one past the device, selects the last block. The result is a two-bit state per block (unknown, good or bad) held in flops and visible in parallel. A scan finishes with a one-cycle done pulse, or with a one-cycle error pulse when a page read fails. A failed read stops the scan and leaves the remaining blocks untouched.

Top module: `nand_bbt_scan`

## Requirements
- R1: After synchronous reset every block reads unknown (`blk_known` and `blk_bad` all zero), `done`, `err`, `busy` and `rd_req_valid` are low.
- R2: A start index that is negative or greater than or equal to `blk_count` is replaced by block 0.
- R3: An end index equal to -1, or greater than or equal to `blk_count`, is replaced by `blk_count`-1. If the clamped start is above the clamped end, nothing is read and `done` pulses in the cycle after `start` is sampled.
- R4: Blocks are visited in ascending order, one read request per block. The request page for block b is b times `pages_per_blk`, the first page of the block.
- R5: `rd_req_valid` stays high with `rd_req_page` stable until `rd_req_ready` is sampled high. At most one read is outstanding, and no new request is raised while a response is presented.
- R6: Spare byte k sits in `rd_rsp_data[8k+7:8k]`. With `bus16` high, a block is bad when spare byte 0 AND spare byte 1 is not 0xFF.
- R7: `pg_kind` 1 means 512-byte pages: the block is bad when spare byte 5 is not 0xFF. `pg_kind` 2 means 2048-byte pages: the block is bad when spare byte 0 is not 0xFF. `pg_kind` 0 and 3 add no page-size rule. Spare bytes 2 to 4, and byte 1 on an 8-bit bus, never affect the result.
- R8: A response with `rd_rsp_err` high ends the scan. `err` pulses for one cycle in the following cycle, no further request is made, `done` does not pulse, and the failing block and all later blocks keep their previous state.
- R9: After the last block in range is classified, `done` is high for exactly one cycle. It appears in the cycle after that block's response, together with the bitmap update.
- R10: Blocks outside the scanned range keep their state across scans. A rescan of a block overwrites its earlier result.
- R11: Each block's state is encoded as known=0 for unknown, known=1 with bad=0 for good, and known=1 with bad=1 for bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a scan when idle |
| first_blk | input | IDX_W | First block index, signed |
| last_blk | input | IDX_W | Last block index, signed (-1 = through the end) |
| blk_count | input | IDX_W | Number of blocks on the device (at most NUM_BLK) |
| pages_per_blk | input | PPB_W | Pages in one erase block |
| pg_kind | input | 2 | Page-size class: 1 = 512 B, 2 = 2048 B, others = neither |
| bus16 | input | 1 | Device uses a 16-bit bus |
| rd_req_valid | output | 1 | Spare-area read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_page | output | PAGE_W | Page number to read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 48 | Six spare bytes, byte k in bits 8k+7:8k |
| rd_rsp_err | input | 1 | Read failed |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: range finished |
| err | output | 1 | One-cycle pulse: scan aborted on a read error |
| blk_known | output | NUM_BLK | Per-block classified flag |
| blk_bad | output | NUM_BLK | Per-block bad flag |

## Verification
The marker rules are swept over all pairs of bus width and page-size class. Each block's spare bytes are coded so that every combination of a dirty byte 0, byte 1 and byte 5 appears, and bytes 2 to 4 are never 0xFF. A missing, swapped or over-eager rule therefore shows up as a wrong block. Bound cases are chosen so that each clamp path is taken on its own: a negative start, a start past the device, -1 as the end, an end past the device, a reduced block count, an inverted range and an empty device. An injected read error in mid-range separates correct abort behaviour from a scan that either keeps going or corrupts the failing block. The ready line stalls on a pseudo-random pattern throughout, which exercises the request hold rule.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int SPARE_BYTES = 6;
    localparam logic [7:0] MARK_CLEAN = 8'hFF;

    // Spare byte positions that the marker rules decode
    localparam int WIDE_LO_IDX = 0;
    localparam int WIDE_HI_IDX = 1;
    localparam int SMALL_PG_IDX = 5;
    localparam int LARGE_PG_IDX = 0;

    typedef logic [SPARE_BYTES-1:0][7:0] spare_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } scan_st_e;

    typedef enum logic [1:0] {
        PG_OTHER = 2'd0,
        PG_SMALL = 2'd1,
        PG_LARGE = 2'd2,
        PG_RSVD  = 2'd3
    } pg_kind_e;

    typedef struct packed {
        logic     bus16;
        pg_kind_e kind;
    } geo_t;

    function automatic logic byte_dirty(input logic [7:0] b);
        return b != MARK_CLEAN;
    endfunction

endpackage

// File: rtl/nbs_clamp.sv
module nbs_clamp #(
    parameter int IDX_W = 16
) (
    input  logic signed [IDX_W-1:0] first_i,
    input  logic signed [IDX_W-1:0] last_i,
    input  logic        [IDX_W-1:0] count_i,
    output logic signed [IDX_W:0]   first_o,
    output logic signed [IDX_W:0]   last_o
);
    localparam logic signed [IDX_W:0] ZERO = '0;
    localparam logic signed [IDX_W:0] ONE  = {{IDX_W{1'b0}}, 1'b1};
    localparam logic signed [IDX_W:0] NEG1 = '1;

    logic signed [IDX_W:0] f_s, l_s, c_s;

    assign f_s = {first_i[IDX_W-1], first_i};
    assign l_s = {last_i[IDX_W-1], last_i};
    assign c_s = {1'b0, count_i};

    always_comb begin
        first_o = ((f_s < ZERO) || (f_s >= c_s)) ? ZERO : f_s;
        last_o  = ((l_s == NEG1) || (l_s >= c_s)) ? (c_s - ONE) : l_s;
    end
endmodule

// File: rtl/nbs_classify.sv
module nbs_classify
    import nbs_pkg::*;
(
    input  spare_t spare_i,
    input  geo_t   geo_i,
    output logic   bad_o
);
    logic wide_bad, size_bad;

    always_comb begin
        wide_bad = geo_i.bus16 &&
                   byte_dirty(spare_i[WIDE_LO_IDX] & spare_i[WIDE_HI_IDX]);
        case (geo_i.kind)
            PG_SMALL: size_bad = byte_dirty(spare_i[SMALL_PG_IDX]);
            PG_LARGE: size_bad = byte_dirty(spare_i[LARGE_PG_IDX]);
            default:  size_bad = 1'b0;
        endcase
        bad_o = wide_bad || size_bad;
    end
endmodule

// File: rtl/nbs_bitmap.sv
module nbs_bitmap #(
    parameter int NUM_BLK = 16,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [BLK_W-1:0]   wr_idx,
    input  logic               wr_bad,
    output logic [NUM_BLK-1:0] known_q,
    output logic [NUM_BLK-1:0] bad_q
);
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                known_q[g] <= 1'b0;
                bad_q[g]   <= 1'b0;
            end else if (wr_en && (wr_idx == BLK_W'(g))) begin
                known_q[g] <= 1'b1;
                bad_q[g]   <= wr_bad;
            end
        end
    end

    AST_KEEP_STATE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (known_q == $past(known_q)) && (bad_q == $past(bad_q))); // R10

    AST_WRITE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> known_q[$past(wr_idx)] && (bad_q[$past(wr_idx)] == $past(wr_bad))); // R11

    AST_BAD_NEEDS_KNOWN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((bad_q & ~known_q) == '0)); // R11
endmodule

// File: rtl/nand_bbt_scan.sv
module nand_bbt_scan
    import nbs_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int IDX_W   = 16,
    parameter int PPB_W   = 8,
    parameter int PAGE_W  = 24,
    localparam int BLK_W  = $clog2(NUM_BLK),
    localparam int SPW    = SPARE_BYTES * 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [IDX_W-1:0]  first_blk,
    input  logic signed [IDX_W-1:0]  last_blk,
    input  logic        [IDX_W-1:0]  blk_count,
    input  logic        [PPB_W-1:0]  pages_per_blk,
    input  logic        [1:0]        pg_kind,
    input  logic                     bus16,
    output logic                     rd_req_valid,
    input  logic                     rd_req_ready,
    output logic        [PAGE_W-1:0] rd_req_page,
    input  logic                     rd_rsp_valid,
    input  logic        [SPW-1:0]    rd_rsp_data,
    input  logic                     rd_rsp_err,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic        [NUM_BLK-1:0] blk_known,
    output logic        [NUM_BLK-1:0] blk_bad
);
    localparam logic signed [IDX_W:0] ZERO   = '0;
    localparam logic signed [IDX_W:0] ONE    = {{IDX_W{1'b0}}, 1'b1};
    localparam logic signed [IDX_W:0] BLK_LIM = (IDX_W+1)'(NUM_BLK);

    scan_st_e              st_q;
    geo_t                  geo_q;
    logic [PPB_W-1:0]      ppb_q;
    logic signed [IDX_W:0] idx_q, last_q;
    logic [PAGE_W-1:0]     page_q;
    logic                  done_q, err_q;

    logic signed [IDX_W:0] first_c, last_c;
    logic                  range_empty;
    logic                  blk_bad_now;
    logic                  upd_en;

    nbs_clamp #(.IDX_W(IDX_W)) u_clamp (
        .first_i (first_blk),
        .last_i  (last_blk),
        .count_i (blk_count),
        .first_o (first_c),
        .last_o  (last_c)
    );

    nbs_classify u_cls (
        .spare_i (spare_t'(rd_rsp_data)),
        .geo_i   (geo_q),
        .bad_o   (blk_bad_now)
    );

    assign range_empty = first_c > last_c;
    assign upd_en      = (st_q == ST_WAIT) && rd_rsp_valid && !rd_rsp_err;

    nbs_bitmap #(.NUM_BLK(NUM_BLK)) u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (upd_en),
        .wr_idx  (idx_q[BLK_W-1:0]),
        .wr_bad  (blk_bad_now),
        .known_q (blk_known),
        .bad_q   (blk_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            geo_q  <= '0;
            ppb_q  <= '0;
            idx_q  <= '0;
            last_q <= '0;
            page_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        geo_q  <= '{bus16: bus16, kind: pg_kind_e'(pg_kind)};
                        ppb_q  <= pages_per_blk;
                        idx_q  <= first_c;
                        last_q <= last_c;
                        page_q <= PAGE_W'(first_c[IDX_W-1:0]) * PAGE_W'(pages_per_blk);
                        if (range_empty) done_q <= 1'b1;
                        else             st_q   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (rd_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (rd_rsp_err) begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else if (idx_q == last_q) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            idx_q  <= idx_q + ONE;
                            page_q <= page_q + PAGE_W'(ppb_q);
                            st_q   <= ST_REQ;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_valid = (st_q == ST_REQ);
    assign rd_req_page  = page_q;
    assign busy         = (st_q != ST_IDLE);
    assign done         = done_q;
    assign err          = err_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_page))); // R5

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_rsp_valid |-> !rd_req_valid); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        err |-> (!done && !rd_req_valid)); // R8

    AST_START_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (blk_count != '0)) |->
        ((first_c >= ZERO) && (first_c < $signed({1'b0, blk_count})) &&
         (last_c < $signed({1'b0, blk_count})))); // R2

    AST_COUNT_FITS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> ({1'b0, blk_count} <= BLK_LIM)); // R3

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> ((idx_q >= ZERO) && (idx_q < BLK_LIM))); // R4
endmodule

// File: tb/tb_nand_bbt_scan.sv
`timescale 1ns/1ps
module tb_nand_bbt_scan;
    localparam int NB = 16;
    localparam int IW = 16;
    localparam int PW = 8;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 start;
    logic signed [IW-1:0] first_blk, last_blk;
    logic [IW-1:0]        blk_count;
    logic [PW-1:0]        pages_per_blk;
    logic [1:0]           pg_kind;
    logic                 bus16;
    logic                 rd_req_valid, rd_req_ready;
    logic [AW-1:0]        rd_req_page;
    logic                 rd_rsp_valid, rd_rsp_err;
    logic [47:0]          rd_rsp_data;
    logic                 busy, done, err;
    logic [NB-1:0]        blk_known, blk_bad;

    nand_bbt_scan #(.NUM_BLK(NB), .IDX_W(IW), .PPB_W(PW), .PAGE_W(AW)) dut (
        .clk(clk), .rst(rst), .start(start),
        .first_blk(first_blk), .last_blk(last_blk), .blk_count(blk_count),
        .pages_per_blk(pages_per_blk), .pg_kind(pg_kind), .bus16(bus16),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_page(rd_req_page),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .busy(busy), .done(done), .err(err),
        .blk_known(blk_known), .blk_bad(blk_bad)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit exp_known [NB];
    bit exp_bad   [NB];

    int            seed_q = 0;
    int            ppb_cur = 1;
    logic          inj_err = 1'b0;
    logic [AW-1:0] err_page = '0;
    logic          log_clr = 1'b0;
    logic [7:0]    lfsr;
    int            n_req;
    int            hs_viol;
    logic          prev_stall;
    logic [AW-1:0] prev_page;
    logic [AW-1:0] req_log [0:63];

    // Spare bytes of a block: bits of a per-block code pick dirty bytes 0, 1 and 5;
    // bytes 2..4 are always 0x00 and must never matter.
    function automatic logic [47:0] spare_of(input int blk, input int seed);
        int c;
        logic [7:0] b0, b1, b5;
        c  = (blk * 5 + seed) & 7;
        b0 = c[0] ? 8'hFE : 8'hFF;
        b1 = c[1] ? 8'h7F : 8'hFF;
        b5 = c[2] ? 8'h00 : 8'hFF;
        return {b5, 8'h00, 8'h00, 8'h00, b1, b0};
    endfunction

    function automatic bit bad_of(input int blk, input int seed, input int b16, input int kind);
        logic [47:0] s;
        bit r;
        s = spare_of(blk, seed);
        r = 1'b0;
        if (b16 != 0 && ((s[7:0] & s[15:8]) != 8'hFF)) r = 1'b1;
        if (kind == 1 && s[47:40] != 8'hFF) r = 1'b1;
        if (kind == 2 && s[7:0] != 8'hFF) r = 1'b1;
        return r;
    endfunction

    // Page-read agent with pseudo-random ready and one-cycle response latency
    always @(posedge clk) begin
        if (rst) begin
            rd_rsp_valid <= 1'b0;
            rd_rsp_err   <= 1'b0;
            rd_rsp_data  <= '0;
            rd_req_ready <= 1'b0;
            lfsr         <= 8'h5A;
            n_req        <= 0;
            hs_viol      <= 0;
            prev_stall   <= 1'b0;
            prev_page    <= '0;
        end else begin
            lfsr         <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rd_req_ready <= lfsr[0] | lfsr[3];
            rd_rsp_valid <= 1'b0;
            rd_rsp_err   <= 1'b0;
            if (prev_stall && (!rd_req_valid || rd_req_page != prev_page)) hs_viol <= hs_viol + 1;
            if (rd_req_valid && rd_rsp_valid) hs_viol <= hs_viol + 1;
            prev_stall <= rd_req_valid && !rd_req_ready;
            prev_page  <= rd_req_page;
            if (rd_req_valid && rd_req_ready) begin
                rd_rsp_valid <= 1'b1;
                rd_rsp_data  <= spare_of(int'(rd_req_page) / ppb_cur, seed_q);
                rd_rsp_err   <= inj_err && (rd_req_page == err_page);
                if (n_req < 64) req_log[n_req] <= rd_req_page;
                n_req <= n_req + 1;
            end
            if (log_clr) begin
                n_req   <= 0;
                hs_viol <= 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_scan(input string tag, input int f, input int l, input int cnt,
                            input int ppb, input int kind, input int b16, input int seed,
                            input int inj, input int eblk);
        int fc, lc, n_exp, dn, er, mism;
        bit exp_err;
        logic [NB-1:0] ek, eb;
        @(negedge clk);
        first_blk = IW'(f); last_blk = IW'(l); blk_count = IW'(cnt);
        pages_per_blk = PW'(ppb); pg_kind = 2'(kind); bus16 = (b16 != 0);
        seed_q = seed; ppb_cur = ppb; inj_err = (inj != 0); err_page = AW'(eblk * ppb);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dn = 0; er = 0;
        for (int k = 0; k < 4000; k++) begin
            if (done) dn++;
            if (err) er++;
            if ((dn + er) > 0 && !busy) break;
            @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) dn++;
            if (err) er++;
        end
        // Expected result from the requirements
        fc = (f < 0 || f >= cnt) ? 0 : f;
        lc = (l == -1 || l >= cnt) ? cnt - 1 : l;
        n_exp = 0; exp_err = 1'b0;
        for (int b = fc; b <= lc; b++) begin
            n_exp++;
            if (inj != 0 && b == eblk) begin
                exp_err = 1'b1;
                break;
            end
            exp_known[b] = 1'b1;
            exp_bad[b]   = bad_of(b, seed, b16, kind);
        end
        chk("R9", {tag, " done pulse count"}, dn, exp_err ? 0 : 1);
        chk("R8", {tag, " err pulse count"}, er, exp_err ? 1 : 0);
        chk("R4", {tag, " request count"}, n_req, n_exp);
        mism = 0;
        for (int i = 0; i < n_exp && i < 64; i++)
            if (req_log[i] != AW'((fc + i) * ppb)) mism++;
        chk("R4", {tag, " request pages"}, mism, 0);
        chk("R5", {tag, " handshake violations"}, hs_viol, 0);
        for (int b = 0; b < NB; b++) begin
            ek[b] = exp_known[b];
            eb[b] = exp_bad[b];
        end
        chk(tag, "R11 known bitmap", blk_known, ek);
        chk(tag, "R11 bad bitmap", blk_bad, eb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        start = 1'b0; first_blk = '0; last_blk = '0; blk_count = IW'(NB);
        pages_per_blk = 8'd1; pg_kind = 2'd0; bus16 = 1'b0;
        for (int b = 0; b < NB; b++) begin
            exp_known[b] = 1'b0;
            exp_bad[b]   = 1'b0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset known", blk_known, 0);
        chk("R1", "reset bad", blk_bad, 0);
        chk("R1", "reset done/err/busy/req", {done, err, busy, rd_req_valid}, 0);

        // R6 and R7: sweep bus width, page-size class and code seeds over the full device
        for (int b16 = 0; b16 < 2; b16++)
            for (int kind = 0; kind < 4; kind++)
                for (int sd = 0; sd < 3; sd++)
                    run_scan(b16 ? "R6" : "R7", 0, NB - 1, NB, 32 + sd * 16, kind, b16, sd, 0, 0);

        run_scan("R7", 2, 9, NB, 64, 2, 0, 3, 0, 0);
        run_scan("R6", 4, 12, NB, 16, 0, 1, 1, 0, 0);
        run_scan("R4", 0, -1, NB, 255, 1, 1, 5, 0, 0);

        // Bounds (R2, R3)
        run_scan("R2", -3, 5, NB, 32, 1, 0, 4, 0, 0);
        run_scan("R2", 20, 7, NB, 32, 2, 0, 6, 0, 0);
        run_scan("R3", 10, -1, NB, 16, 2, 1, 7, 0, 0);
        run_scan("R3", 12, 40, NB, 16, 1, 0, 2, 0, 0);
        run_scan("R3", 3, -1, 10, 8, 1, 1, 1, 0, 0);
        run_scan("R3", 9, 4, NB, 8, 1, 0, 0, 0, 0);
        run_scan("R3", 0, 0, 0, 8, 2, 0, 0, 0, 0);
        run_scan("R3", 2, -5, NB, 8, 2, 0, 3, 0, 0);

        // Partial rescan leaves the rest (R10)
        run_scan("R10", 5, 8, NB, 32, 2, 1, 5, 0, 0);

        // Read error mid-range (R8)
        run_scan("R8", 0, NB - 1, NB, 32, 1, 1, 2, 1, 6);
        run_scan("R8", 3, 9, NB, 16, 2, 0, 7, 1, 3);
        run_scan("R10", 0, NB - 1, NB, 32, 1, 0, 1, 0, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_fail);
        $finish;
    end
endmodule